// File: doc/BRIEF.md
# Bus Tenure Limit Timer

This block caps how long a bus master may hold the system bus while it moves FIFO payload data. Software stores a 16-bit limit in a programmable register. One count stands for 0.1 µs, so a value of 510 (1FEh) gives 51 µs. When a new bus ownership period begins, a separate run-time down-counter is loaded from that register. After the bus is granted and seen idle, the counter steps down once on every tick from an external 0.1 µs prescaler. When it reaches zero, the block lets the data phase in flight finish and then raises a release request. The arbitration protocol and any clock-domain crossing stay outside the block.

The tenure is tracked by a five-state machine:
- `ST_OFF`: no grant is held.
- `ST_WAIT`: the bus is granted and the counter has just been reloaded, but the bus is not yet idle.
- `ST_RUN`: counting is under way.
- `ST_DRAIN`: the limit has expired and the block waits for the current data phase to end.
- `ST_REL`: the release request is being shown.

The transitions are:
- `OFF→WAIT` on grant. This transition reloads the counter.
- `WAIT→RUN` on idle.
- `RUN→DRAIN` when the count is zero, enforcement is on and the traffic is FIFO data.
- `DRAIN→REL` when a FIFO data phase completes.
- `DRAIN→RUN` and `REL→RUN` when enforcement is switched off.
- Any state returns to `OFF` when the grant drops or on software reset.

The register word is 32 bits, with the limit in bits 15:0. A read returns the live counter, not the stored limit. Reads and writes are honoured only while the stop or suspend control bit is high.

Top module: `bus_tenure_limiter`

## Requirements
- R1: After hardware reset (`rst_n` low) or a software reset pulse (`soft_rst`), both the stored limit and the run-time counter are 0 and `release_req` is low.
- R2: A write (`reg_wr`) updates the stored limit only when `ctl_stop` or `ctl_susp` is high. A write at any other time leaves the limit unchanged.
- R3: While `reg_rd` is high and `ctl_stop` or `ctl_susp` is high, `reg_rdata` is {16'h0000, run-time counter}, the same cycle. Otherwise `reg_rdata` is 0.
- R4: Bits 31:16 of `reg_wdata` are ignored on a write, and bits 31:16 of `reg_rdata` always read 0.
- R5: The counter is reloaded from the stored limit only on the cycle a grant starts (`bus_grant` seen high in `ST_OFF`). If a write lands on that same cycle, the counter takes the old limit.
- R6: In `ST_RUN`, each cycle with `tick` high lowers the counter by one. At zero it holds zero and never wraps.
- R7: With `limit_en` and `fifo_xfer` high, a zero count moves the machine to `ST_DRAIN`. `release_req` stays low until a cycle with `xfer_done` high, then goes high on the next cycle and holds while the grant lasts.
- R8: A stored limit of 0 lets exactly one data phase complete before `release_req` rises.
- R9: With `limit_en` low, `release_req` never rises.
- R10: While `fifo_xfer` is low (descriptor or initialisation traffic), `release_req` is low and `xfer_done` does not advance the machine toward release.
- R11: Raising `ctl_stop` does not alter the stored limit or the counter.
- R12: When `bus_grant` goes low, the machine is in `ST_OFF` on the next cycle and `release_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset, synchronous, active high |
| limit_en | input | 1 | Enables enforcement of the tenure limit |
| bus_grant | input | 1 | Bus ownership is held |
| bus_idle | input | 1 | Bus is idle (starts the count after a grant) |
| fifo_xfer | input | 1 | 1 = FIFO data traffic, 0 = descriptor or initialisation traffic |
| xfer_done | input | 1 | The current data phase completes this cycle |
| tick | input | 1 | One-cycle 0.1 µs timebase pulse |
| ctl_stop | input | 1 | Stop control bit, qualifies register access |
| ctl_susp | input | 1 | Suspend control bit, qualifies register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data (limit in 15:0) |
| reg_rdata | output | 32 | Register read data (live counter in 15:0) |
| release_req | output | 1 | Request to give up the bus |

## Verification
A register write and the start of a new grant can land on the same clock edge. The write updates the stored limit, while the reload samples that limit for the run-time counter. The bench raises `reg_wr` with a new value and `bus_grant` together. Reading the counter right after must give the old limit, and only the next grant must pick up the new value. A tick at a zero count is also driven, and the counter must still read zero.

// File: rtl/tlt_pkg.sv
`timescale 1ns/1ps
package tlt_pkg;
    // Tenure tracking states
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_WAIT  = 3'd1,
        ST_RUN   = 3'd2,
        ST_DRAIN = 3'd3,
        ST_REL   = 3'd4
    } tlt_state_e;
endpackage

// File: rtl/tlt_limit_reg.sv
`timescale 1ns/1ps
module tlt_limit_reg #(
    parameter int CNT_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ctl_stop,
    input  logic              ctl_susp,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [CNT_W-1:0]  limit,
    output logic [WORD_W-1:0] reg_rdata
);
    localparam int RSV_W = WORD_W - CNT_W;

    logic access_ok;
    assign access_ok = ctl_stop | ctl_susp;

    // Stored limit; only the low field of the word is kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit <= '0;
        end else if (clr) begin
            limit <= '0;
        end else if (reg_wr && access_ok) begin
            limit <= reg_wdata[CNT_W-1:0];
        end
    end

    // Read path shows the live counter, reserved field zero
    always_comb begin
        reg_rdata = '0;
        if (reg_rd && access_ok) begin
            reg_rdata = {{RSV_W{1'b0}}, live_cnt};
        end
    end

    // R2
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !access_ok && !clr) |=> $stable(limit));
endmodule

// File: rtl/tlt_counter.sv
`timescale 1ns/1ps
module tlt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign cnt_zero = (cnt == '0);

    // Priority: clear, reload, saturating decrement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && !cnt_zero) begin
            cnt <= cnt - ONE;
        end
    end

    // R6
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> (cnt == '0));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr && cnt != '0) |=>
            (cnt == $past(cnt) || cnt == $past(cnt) - ONE));
endmodule

// File: rtl/tlt_fsm.sv
`timescale 1ns/1ps
module tlt_fsm
    import tlt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       limit_en,
    input  logic       bus_grant,
    input  logic       bus_idle,
    input  logic       fifo_xfer,
    input  logic       xfer_done,
    input  logic       cnt_zero,
    output logic       load,
    output logic       dec_en,
    output logic       release_req,
    output tlt_state_e state
);
    tlt_state_e next;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else if (soft_rst) begin
            state <= ST_OFF;
        end else begin
            state <= next;
        end
    end

    // Next-state logic
    always_comb begin
        next = state;
        unique case (state)
            ST_OFF: begin
                if (bus_grant) next = ST_WAIT;
            end
            ST_WAIT: begin
                if (!bus_grant)    next = ST_OFF;
                else if (bus_idle) next = ST_RUN;
            end
            ST_RUN: begin
                if (!bus_grant)                            next = ST_OFF;
                else if (limit_en && fifo_xfer && cnt_zero) next = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!bus_grant)                  next = ST_OFF;
                else if (!limit_en)              next = ST_RUN;
                else if (fifo_xfer && xfer_done) next = ST_REL;
            end
            ST_REL: begin
                if (!bus_grant)     next = ST_OFF;
                else if (!limit_en) next = ST_RUN;
            end
            default: next = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        load        = (state == ST_OFF) && bus_grant && !soft_rst;
        dec_en      = (state == ST_RUN);
        release_req = (state == ST_REL) && fifo_xfer && limit_en;
    end

    // R7
    rel_from_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REL && $past(state) != ST_REL) |-> ($past(state) == ST_DRAIN));

    // R12
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_grant |=> (state == ST_OFF));
endmodule

// File: rtl/bus_tenure_limiter.sv
`timescale 1ns/1ps
module bus_tenure_limiter #(
    parameter int CNT_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              limit_en,
    input  logic              bus_grant,
    input  logic              bus_idle,
    input  logic              fifo_xfer,
    input  logic              xfer_done,
    input  logic              tick,
    input  logic              ctl_stop,
    input  logic              ctl_susp,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              release_req
);
    import tlt_pkg::*;

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;
    logic             load;
    logic             dec_en;
    tlt_state_e       state;

    tlt_limit_reg #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_rst),
        .ctl_stop  (ctl_stop),
        .ctl_susp  (ctl_susp),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .live_cnt  (cnt),
        .limit     (limit),
        .reg_rdata (reg_rdata)
    );

    tlt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .load     (load),
        .load_val (limit),
        .dec      (dec_en & tick),
        .cnt      (cnt),
        .cnt_zero (cnt_zero)
    );

    tlt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .limit_en    (limit_en),
        .bus_grant   (bus_grant),
        .bus_idle    (bus_idle),
        .fifo_xfer   (fifo_xfer),
        .xfer_done   (xfer_done),
        .cnt_zero    (cnt_zero),
        .load        (load),
        .dec_en      (dec_en),
        .release_req (release_req),
        .state       (state)
    );

    // R9
    no_rel_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!limit_en && !$past(limit_en)) |-> !release_req);
endmodule

// File: tb/bus_tenure_limiter_bench.sv
`timescale 1ns/1ps
module bus_tenure_limiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        limit_en = 1'b0;
    logic        bus_grant = 1'b0;
    logic        bus_idle = 1'b0;
    logic        fifo_xfer = 1'b0;
    logic        xfer_done = 1'b0;
    logic        tick = 1'b0;
    logic        ctl_stop = 1'b0;
    logic        ctl_susp = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        release_req;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    string       tag_q[$];
    bit          kind_q[$];
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    bus_tenure_limiter u_bus_tenure_limiter (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .limit_en(limit_en),
        .bus_grant(bus_grant), .bus_idle(bus_idle), .fifo_xfer(fifo_xfer),
        .xfer_done(xfer_done), .tick(tick), .ctl_stop(ctl_stop),
        .ctl_susp(ctl_susp), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .release_req(release_req)
    );

    // Monitor: pops one expected item per cycle and compares at negedge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            string       t;
            bit          k;
            logic [31:0] e;
            logic [31:0] a;
            t = tag_q.pop_front();
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            a = k ? {31'd0, release_req} : reg_rdata;
            nvec++;
            if (a !== e) begin
                nfail++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic push(input string t, input bit k, input logic [31:0] e);
        tag_q.push_back(t);
        kind_q.push_back(k);
        exp_q.push_back(e);
    endtask

    task automatic chk_rd(input string t, input logic [31:0] e);
        reg_rd = 1'b1;
        push(t, 1'b0, e);
        step(1);
        reg_rd = 1'b0;
    endtask

    task automatic chk_rel(input string t, input bit e);
        push(t, 1'b1, {31'd0, e});
        step(1);
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        step(1);
        xfer_done = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        ctl_stop = 1'b1;
        chk_rd("R1 counter after reset", 32'h0);
        chk_rel("R1 release after reset", 1'b0);

        // R4: upper field ignored, limit becomes 5; counter not yet reloaded
        wr(32'hABCD_0005);
        chk_rd("R5 no reload without grant", 32'h0);
        ctl_stop = 1'b0;
        wr(32'h0000_0009);                       // R2 ignored write
        chk_rd("R3 read gated off", 32'h0);
        bus_grant = 1'b1;
        step(1);                                  // reload, ST_WAIT
        ctl_susp = 1'b1;
        chk_rd("R2 R4 R5 reload value", 32'h0000_0005);

        // R6 countdown
        bus_idle = 1'b1; fifo_xfer = 1'b1; limit_en = 1'b1;
        step(1);                                  // ST_RUN
        tick = 1'b1; step(1); tick = 1'b0;
        chk_rd("R6 one tick", 32'h0000_0004);
        for (int i = 0; i < 4; i++) begin
            tick = 1'b1; step(1); tick = 1'b0;
        end
        chk_rd("R6 reached zero", 32'h0);         // moves to ST_DRAIN
        tick = 1'b1; step(1); tick = 1'b0;
        chk_rd("R6 hold at zero", 32'h0);
        chk_rel("R7 wait for data phase", 1'b0);
        pulse_done();
        chk_rel("R7 release raised", 1'b1);
        chk_rel("R7 release held", 1'b1);
        fifo_xfer = 1'b0;
        chk_rel("R10 descriptor masks release", 1'b0);
        fifo_xfer = 1'b1;
        bus_grant = 1'b0;
        step(1);
        chk_rel("R12 release after grant drop", 1'b0);

        // R5 same-cycle write and reload
        ctl_stop = 1'b1;
        bus_grant = 1'b1;
        wr(32'h0000_0003);
        chk_rd("R5 reload takes old limit", 32'h0000_0005);
        bus_grant = 1'b0; step(1);
        bus_grant = 1'b1; step(1);
        chk_rd("R5 next grant new limit", 32'h0000_0003);
        ctl_susp = 1'b0;
        chk_rd("R11 stop keeps counter", 32'h0000_0003);
        ctl_susp = 1'b1;

        // R8 zero limit
        bus_grant = 1'b0; step(1);
        wr(32'h0);
        bus_grant = 1'b1; step(1);                // ST_WAIT
        step(1);                                  // ST_RUN
        chk_rel("R8 no release before transfer", 1'b0);
        chk_rel("R8 draining", 1'b0);
        pulse_done();
        chk_rel("R8 release after one transfer", 1'b1);
        bus_grant = 1'b0; step(1);

        // R9 enforcement off
        limit_en = 1'b0;
        bus_grant = 1'b1; step(3);
        pulse_done();
        chk_rel("R9 disabled never releases", 1'b0);
        bus_grant = 1'b0; step(1);

        // R10 descriptor traffic
        limit_en = 1'b1; fifo_xfer = 1'b0;
        bus_grant = 1'b1; step(3);
        pulse_done();
        chk_rel("R10 no release on descriptor", 1'b0);
        fifo_xfer = 1'b1;
        chk_rel("R10 back to data, still run", 1'b0);
        chk_rel("R7 drain after switch", 1'b0);
        bus_grant = 1'b0; step(1);

        // R1 software reset
        wr(32'h0000_0007);
        bus_grant = 1'b1; bus_idle = 1'b0; step(1);
        chk_rd("R1 pre soft reset", 32'h0000_0007);
        soft_rst = 1'b1; step(1); soft_rst = 1'b0;
        chk_rd("R1 counter cleared", 32'h0);
        chk_rd("R1 limit cleared", 32'h0);
        chk_rel("R1 release low", 1'b0);

        step(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule